// File: doc/BRIEF.md
# Configurable Synchronous Block RAM Port

This block is one port of an on-chip synchronous RAM. Every access is one clock edge: a write stores the addressed word, or part of it, and a read loads the addressed word into an array-side output latch. A parameter sets what that latch shows on a cycle that writes. It can show the freshly written word, the contents the word held before the write, or it can leave its earlier value untouched. An optional pipeline register after the latch adds one cycle of read latency and is enabled by default.

For the data widths 18, 36 and 72, the word splits into 9-bit lanes (8 data bits plus one extra bit), and each lane has its own write enable. Other widths use a single write enable for the whole word. There are two synchronous resets that load a parameter value. One acts on the array latch and only counts when the port is enabled. The other acts on the output register. A parameter decides whether the register reset overrides the register clock enable or depends on it.

Top module: `sbram_port`

## Requirements
- R1: With the output register off, read data appears on `rdata` after the edge that samples the read. With the register on and `oreg_ce`=1, it appears one edge later.
- R2: In write-first mode, a write cycle loads the latch with the merged word. That word has the new data in the enabled lanes and the old data in the other lanes.
- R3: In read-first mode, a write cycle loads the latch with the word as it stood before the write.
- R4: In no-change mode, a write cycle leaves the latch unchanged. The write to the array still takes place.
- R5: When `DW` is 18, 36 or 72, `wr_en[i]` writes bits [9i+8:9i]. For any other width, `wr_en[0]` writes the whole word. A cycle is a write when any `wr_en` bit is 1, and a read otherwise.
- R6: While `en`=0, the array is neither written nor read, and the latch holds its value. This applies even when `lat_rst`=1.
- R7: `lat_rst`=1 with `en`=1 loads `RST_VAL` into the latch. Any write requested in the same cycle is still performed.
- R8: `oreg_rst` loads `RST_VAL` into the output register and never changes the latch.
- R9: With `RST_WINS`=1, `oreg_rst` acts whatever `oreg_ce` is. With `RST_WINS`=0, `oreg_rst` acts only while `oreg_ce`=1.
- R10: With `oreg_ce`=0 and no reset acting, the output register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| en | input | 1 | Port enable for array access and for the latch |
| wr_en | input | LANES | Per-lane write enables |
| addr | input | $clog2(DEPTH) | Word address |
| wdata | input | DW | Write data |
| oreg_ce | input | 1 | Output register clock enable |
| lat_rst | input | 1 | Synchronous reset of the array latch |
| oreg_rst | input | 1 | Synchronous reset of the output register |
| rdata | output | DW | Read data |

## Verification
Four instances run in parallel on the same inputs. They cover the three read-during-write modes and both register reset priorities. A single stimulus sequence therefore shows at once how they differ on the same write.

Full-word writes separate write-first from read-first. Partial lane writes expose the lane merge and the lane boundaries. Back-to-back writes to one address show whether the old or the new contents reach the latch. Reads with `oreg_ce` low, and resets combined with the enables low, separate the two reset stages and the two priority settings.

// File: rtl/sbram_pkg.sv
package sbram_pkg;

   typedef enum logic [1:0] {
      RDW_WRITE_FIRST = 2'd0,
      RDW_READ_FIRST  = 2'd1,
      RDW_NO_CHANGE   = 2'd2
   } rdw_mode_e;

   localparam int LANE_BITS = 9;

   function automatic int lane_count(input int dw);
      return (dw == 18 || dw == 36 || dw == 72) ? dw / LANE_BITS : 1;
   endfunction

endpackage

// File: rtl/sbram_array.sv
module sbram_array #(
   parameter int DW    = 36,
   parameter int DEPTH = 256,
   parameter int LANES = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = DW / LANES
) (
   input  logic             clk,
   input  logic             en,
   input  logic [LANES-1:0] wr_en,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    old_word,
   output logic [DW-1:0]    mrg_word
);

   logic [DW-1:0] mem [DEPTH];

   assign old_word = mem[addr];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign mrg_word[l*LW +: LW] = wr_en[l] ? wdata[l*LW +: LW] : old_word[l*LW +: LW];
   end

   always_ff @(posedge clk) begin
      if (en && (|wr_en))
         mem[addr] <= mrg_word;
   end

endmodule

// File: rtl/sbram_latch.sv
module sbram_latch #(
   parameter int DW = 36,
   parameter sbram_pkg::rdw_mode_e MODE = sbram_pkg::RDW_WRITE_FIRST,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          en,
   input  logic          is_wr,
   input  logic          lat_rst,
   input  logic [DW-1:0] old_word,
   input  logic [DW-1:0] mrg_word,
   output logic [DW-1:0] lat_q
);

   logic [DW-1:0] wr_view;

   if (MODE == sbram_pkg::RDW_WRITE_FIRST) begin : g_wf
      assign wr_view = mrg_word;
   end else if (MODE == sbram_pkg::RDW_READ_FIRST) begin : g_rf
      assign wr_view = old_word;
   end else begin : g_nc
      assign wr_view = lat_q;
   end

   always_ff @(posedge clk) begin
      if (en) begin
         if (lat_rst)
            lat_q <= RST_VAL;
         else if (is_wr)
            lat_q <= wr_view;
         else
            lat_q <= old_word;
      end
   end

   // R6
   lat_hold_chk: assert property (@(posedge clk) !en |=> $stable(lat_q));
   // R7
   lat_rst_chk: assert property (@(posedge clk) (en && lat_rst) |=> lat_q == RST_VAL);

   if (MODE == sbram_pkg::RDW_NO_CHANGE) begin : g_nc_chk
      // R4
      nc_keep_chk: assert property (@(posedge clk) (en && is_wr && !lat_rst) |=> $stable(lat_q));
   end

endmodule

// File: rtl/sbram_oreg.sv
module sbram_oreg #(
   parameter int DW = 36,
   parameter bit RST_WINS = 1'b1,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          ce,
   input  logic          rst,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);

   if (RST_WINS) begin : g_rst_first
      always_ff @(posedge clk) begin
         if (rst)
            q <= RST_VAL;
         else if (ce)
            q <= d;
      end
      // R9
      rst_first_chk: assert property (@(posedge clk) rst |=> q == RST_VAL);
      // R10
      hold_rw_chk: assert property (@(posedge clk) (!ce && !rst) |=> $stable(q));
   end else begin : g_ce_first
      always_ff @(posedge clk) begin
         if (ce)
            q <= rst ? RST_VAL : d;
      end
      // R9
      ce_gate_chk: assert property (@(posedge clk) (rst && ce) |=> q == RST_VAL);
      // R10
      hold_ce_chk: assert property (@(posedge clk) !ce |=> $stable(q));
   end

endmodule

// File: rtl/sbram_port.sv
module sbram_port #(
   parameter int DW    = 36,
   parameter int DEPTH = 256,
   parameter sbram_pkg::rdw_mode_e RDW_MODE = sbram_pkg::RDW_WRITE_FIRST,
   parameter bit OUT_REG  = 1'b1,
   parameter bit RST_WINS = 1'b1,
   parameter logic [DW-1:0] RST_VAL = '0,
   localparam int LANES = sbram_pkg::lane_count(DW),
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             en,
   input  logic [LANES-1:0] wr_en,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic             oreg_ce,
   input  logic             lat_rst,
   input  logic             oreg_rst,
   output logic [DW-1:0]    rdata
);

   if (DW < 1) begin : g_bad_dw
      $error("sbram_port: DW must be positive");
   end
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("sbram_port: DEPTH must be a power of two of at least 2");
   end
   if (DW % LANES != 0) begin : g_bad_lanes
      $error("sbram_port: DW must split evenly into lanes");
   end

   logic [DW-1:0] old_word;
   logic [DW-1:0] mrg_word;
   logic [DW-1:0] lat_q;

   sbram_array #(.DW(DW), .DEPTH(DEPTH), .LANES(LANES)) u_array (
      .clk      (clk),
      .en       (en),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .old_word (old_word),
      .mrg_word (mrg_word)
   );

   sbram_latch #(.DW(DW), .MODE(RDW_MODE), .RST_VAL(RST_VAL)) u_latch (
      .clk      (clk),
      .en       (en),
      .is_wr    (|wr_en),
      .lat_rst  (lat_rst),
      .old_word (old_word),
      .mrg_word (mrg_word),
      .lat_q    (lat_q)
   );

   if (OUT_REG) begin : g_reg
      logic [DW-1:0] reg_q;
      sbram_oreg #(.DW(DW), .RST_WINS(RST_WINS), .RST_VAL(RST_VAL)) u_oreg (
         .clk (clk),
         .ce  (oreg_ce),
         .rst (oreg_rst),
         .d   (lat_q),
         .q   (reg_q)
      );
      assign rdata = reg_q;

      // R1
      reg_stage_chk: assert property (@(posedge clk) (oreg_ce && !oreg_rst) |=> rdata == $past(lat_q));
      // R8
      reg_rst_lat_chk: assert property (@(posedge clk) (!en && oreg_rst) |=> $stable(lat_q));
   end else begin : g_noreg
      assign rdata = lat_q;
   end

endmodule

// File: tb/sbram_port_tb.sv
`timescale 1ns/100ps
module sbram_port_tb;

   localparam int DW    = 36;
   localparam int DEPTH = 16;
   localparam int AW    = 4;
   localparam int LN    = 4;
   localparam logic [DW-1:0] RV = 36'h1_2345_6789;

   logic          clk = 1'b0;
   logic          en = 1'b0;
   logic [LN-1:0] wr_en = '0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          oreg_ce = 1'b0;
   logic          lat_rst = 1'b0;
   logic          oreg_rst = 1'b0;
   logic [DW-1:0] dout_wf, dout_ce, dout_rf, dout_nc;

   always #2.5 clk = ~clk;

   sbram_port #(.DW(DW), .DEPTH(DEPTH), .RDW_MODE(sbram_pkg::RDW_WRITE_FIRST),
                .OUT_REG(1'b1), .RST_WINS(1'b1), .RST_VAL(RV)) u_dut (
      .clk(clk), .en(en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .oreg_ce(oreg_ce), .lat_rst(lat_rst), .oreg_rst(oreg_rst), .rdata(dout_wf));

   sbram_port #(.DW(DW), .DEPTH(DEPTH), .RDW_MODE(sbram_pkg::RDW_WRITE_FIRST),
                .OUT_REG(1'b1), .RST_WINS(1'b0), .RST_VAL(RV)) u_ce (
      .clk(clk), .en(en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .oreg_ce(oreg_ce), .lat_rst(lat_rst), .oreg_rst(oreg_rst), .rdata(dout_ce));

   sbram_port #(.DW(DW), .DEPTH(DEPTH), .RDW_MODE(sbram_pkg::RDW_READ_FIRST),
                .OUT_REG(1'b0), .RST_WINS(1'b1), .RST_VAL(RV)) u_rf (
      .clk(clk), .en(en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .oreg_ce(oreg_ce), .lat_rst(lat_rst), .oreg_rst(oreg_rst), .rdata(dout_rf));

   sbram_port #(.DW(DW), .DEPTH(DEPTH), .RDW_MODE(sbram_pkg::RDW_NO_CHANGE),
                .OUT_REG(1'b0), .RST_WINS(1'b1), .RST_VAL(RV)) u_nc (
      .clk(clk), .en(en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .oreg_ce(oreg_ce), .lat_rst(lat_rst), .oreg_rst(oreg_rst), .rdata(dout_nc));

   // reference model
   logic [DW-1:0] m_mem [DEPTH];
   logic [DW-1:0] m_wf, m_rf, m_nc, m_rw, m_cq;
   int total = 0;
   int bad = 0;

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input string tag, input bit check, input logic e, input logic [LN-1:0] w,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic rl, input logic rr, input logic ce);
      logic [DW-1:0] old, mrg;
      en = e; wr_en = w; addr = a; wdata = d; lat_rst = rl; oreg_rst = rr; oreg_ce = ce;
      old = m_mem[a];
      for (int l = 0; l < LN; l++)
         mrg[l*9 +: 9] = w[l] ? d[l*9 +: 9] : old[l*9 +: 9];
      if (rr) m_rw = RV; else if (ce) m_rw = m_wf;
      if (ce) m_cq = rr ? RV : m_wf;
      if (e) begin
         if (rl) begin
            m_wf = RV; m_rf = RV; m_nc = RV;
         end else if (|w) begin
            m_wf = mrg; m_rf = old;
         end else begin
            m_wf = old; m_rf = old; m_nc = old;
         end
         if (|w) m_mem[a] = mrg;
      end
      @(posedge clk);
      @(negedge clk);
      if (check) begin
         chk({tag, " write-first reg (R1 R2)"}, dout_wf, m_rw);
         chk({tag, " ce-priority reg (R9)"}, dout_ce, m_cq);
         chk({tag, " read-first latch (R3)"}, dout_rf, m_rf);
         chk({tag, " no-change latch (R4)"}, dout_nc, m_nc);
      end
   endtask

   // {en, wr_en[3:0], addr[3:0], wdata[35:0], lat_rst, oreg_rst, oreg_ce}
   localparam logic [47:0] TBL [18] = '{
      {1'b1, 4'h0, 4'd0, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1}, // read
      {1'b1, 4'hF, 4'd1, 36'hA_BCDE_F012, 1'b0, 1'b0, 1'b1}, // R2 R3 full write
      {1'b1, 4'h0, 4'd1, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1}, // R1 read back
      {1'b1, 4'h5, 4'd1, 36'h5_5555_5555, 1'b0, 1'b0, 1'b1}, // R5 lanes 0 and 2
      {1'b1, 4'h0, 4'd1, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1}, // R5 merged word
      {1'b1, 4'h8, 4'd2, 36'hF_FFFF_FFFF, 1'b0, 1'b0, 1'b1}, // R5 top lane
      {1'b0, 4'hF, 4'd3, 36'h3_3333_3333, 1'b1, 1'b0, 1'b1}, // R6 disabled
      {1'b1, 4'h0, 4'd3, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1}, // R6 not written
      {1'b1, 4'hF, 4'd3, 36'h7_7777_7777, 1'b1, 1'b0, 1'b1}, // R7 reset + write
      {1'b1, 4'h0, 4'd3, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1}, // R7 write landed
      {1'b1, 4'h0, 4'd2, 36'h0_0000_0000, 1'b0, 1'b0, 1'b0}, // R10 ce low
      {1'b1, 4'h0, 4'd4, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1},
      {1'b1, 4'h2, 4'd4, 36'h0_0000_01FF, 1'b0, 1'b0, 1'b1}, // R5 lane 1 only
      {1'b1, 4'hF, 4'd5, 36'h9_8765_4321, 1'b0, 1'b0, 1'b1}, // back-to-back
      {1'b1, 4'h1, 4'd5, 36'h0_0000_00AA, 1'b0, 1'b0, 1'b1}, // R3 old = prior write
      {1'b1, 4'h0, 4'd5, 36'h0_0000_0000, 1'b0, 1'b1, 1'b1}, // R8 R9 both reset
      {1'b1, 4'h0, 4'd6, 36'h0_0000_0000, 1'b0, 1'b1, 1'b0}, // R9 priority split
      {1'b1, 4'h0, 4'd5, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1}
   };

   initial begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
      m_wf = '0; m_rf = '0; m_nc = '0; m_rw = '0; m_cq = '0;
      @(negedge clk);
      // R7 R8 reset state
      drive("reset state R7 R8", 1'b1, 1'b1, 4'h0, 4'd0, '0, 1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 8; i++)
         drive("prefill", 1'b0, 1'b1, 4'hF, AW'(i), {4{9'(i * 37 + 5)}}, 1'b0, 1'b0, 1'b1);
      drive("sync", 1'b0, 1'b1, 4'h0, 4'd0, '0, 1'b0, 1'b0, 1'b1);
      drive("sync", 1'b0, 1'b1, 4'h0, 4'd0, '0, 1'b0, 1'b0, 1'b1);
      for (int k = 0; k < 18; k++) begin
         logic [47:0] v;
         v = TBL[k];
         drive($sformatf("table[%0d]", k), 1'b1, v[47], v[46:43], v[42:39], v[38:3],
               v[2], v[1], v[0]);
      end
      // R8: register reset with port disabled, then latch value reappears
      drive("R8 reg reset", 1'b1, 1'b0, 4'h0, 4'd0, '0, 1'b0, 1'b1, 1'b1);
      chk("R8 reg reset value", dout_wf, RV);
      drive("R8 latch kept", 1'b1, 1'b0, 4'h0, 4'd0, '0, 1'b0, 1'b0, 1'b1);
      chk("R8 latch not cleared", dout_wf, m_mem[5]);
      // R9: reset with ce low, only the reset-wins register clears
      drive("R9 rst ce low", 1'b1, 1'b0, 4'h0, 4'd0, '0, 1'b0, 1'b1, 1'b0);
      chk("R9 rst-wins clears", dout_wf, RV);
      chk("R9 ce-wins holds", dout_ce, m_mem[5]);
      // R1: latency difference between latch and register outputs
      drive("R1 lat", 1'b1, 1'b1, 4'h0, 4'd1, '0, 1'b0, 1'b0, 1'b1);
      chk("R1 no-reg one edge", dout_rf, m_mem[1]);
      drive("R1 reg", 1'b1, 1'b1, 4'h0, 4'd1, '0, 1'b0, 1'b0, 1'b1);
      chk("R1 reg two edges", dout_wf, m_mem[1]);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule